// File: doc/BRIEF.md
# Lockable Four-Way Data Cache

This block sits between a processor's load/store port and a burst-capable memory bus. It holds 4 KB of data as 64 sets of four 16-byte lines. Reads and copy-back stores that hit finish in the cycle they are presented. A miss either refills a whole line with a four-beat burst or, when allocation is not allowed, becomes a single-word bus access. A dirty victim is written back as a four-beat burst before its replacement is fetched.

Two live controls shape its behaviour. `copyBack` selects the store policy. When it is high, stores stay in the cache and mark the line dirty. When it is low, every store is also sent to memory, and a store miss does not allocate. `freeze` stops all allocation and replacement without invalidating anything: lines already present keep hitting, and every miss is served as an uncached single-word access. The processor holds its request stable until `respDone` pulses.

Top module: `lockable_dcache`

## Requirements
- R1: A read that hits returns the addressed word with `respDone` high in the same cycle it is presented, and starts no bus transaction.
- R2: A read miss that may allocate fetches the line with one read burst (`memBurst`=1, four beats) starting at the line-aligned address. It then returns the requested word, and later reads of any word in that line hit.
- R3: With `copyBack`=1, a store hit updates the cached word and marks the line dirty in its own cycle, with no bus transaction. Memory keeps its old value.
- R4: With `copyBack`=0, a store hit updates the cached word and issues one single-word bus write (`memBurst`=0, `memWrite`=1). `respDone` is given in the cycle the bus acknowledges it.
- R5: With `copyBack`=0, a store miss becomes one single-word bus write and allocates no line, so a later read of that address misses.
- R6: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, a 3-bit tree pseudo-LRU chooses it. Bit 0 clear selects ways 0/1 and set selects ways 2/3. Bit 1 chooses way 0 or way 1, and bit 2 chooses way 2 or way 3. Every hit and every fill points the bits away from the way just used.
- R7: A miss whose victim is dirty first writes the victim's four words back as one write burst and then starts the refill burst. No dirty line is ever overwritten.
- R8: While `freeze`=1, hits are served normally. A miss of either kind is served as a single-word uncached access and allocates or evicts nothing. After `freeze` falls, allocation resumes.
- R9: Reset invalidates every line and leaves `memReq` and `respDone` low.
- R10: Once raised, `memReq` stays high with a stable address until the transaction's last beat is acknowledged. A burst starts at the line base and a single access uses the word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| copyBack | input | 1 | 1 = copy-back stores, 0 = write-through |
| freeze | input | 1 | 1 = no allocation or replacement |
| reqValid | input | 1 | Processor request, held until `respDone` |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Word-aligned byte address |
| reqWdata | input | 32 | Store data |
| respDone | output | 1 | Request completes this cycle |
| respData | output | 32 | Load data, valid with `respDone` |
| memReq | output | 1 | Bus transaction active |
| memWrite | output | 1 | 1 = bus write |
| memBurst | output | 1 | 1 = four-beat line burst, 0 = single word |
| memAddr | output | 32 | Line base (burst) or word address (single) |
| memWdata | output | 32 | Write data of the current beat |
| memAck | input | 1 | Bus accepts or returns one beat this cycle |
| memRdata | input | 32 | Read data, valid with `memAck` |

## Verification
Hits are due with zero rising edges between presenting the request and seeing `respDone`. A single-word access completes in the cycle of its acknowledge. The bench's memory model acknowledges a beat every second cycle. Under that model, a clean miss returns its word after 8 rising edges, a dirty-victim miss after 16, and a single-word access after 1. The bench drives requests on the falling edge, samples 1 ns later, and counts rising edges until `respDone`. It compares that count with these figures, together with the bus transaction count, kind and address recorded by its memory model.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_SINGLE
  } dcState_t;

  typedef struct packed {
    logic touch;       // refresh replacement bits for the hit way
    logic wrHit;       // write request data into the hit way
    logic markDirty;   // set dirty bit of the hit way
    logic fillBeat;    // store one refill beat into the victim way
    logic fillDone;    // install tag, set valid, clear dirty
    logic wbDone;      // victim has been written back
    logic selVictim;   // bus address and data come from the victim
    logic selWord;     // bus address is the request word address
    logic respFromBus; // response data taken from the bus
  } dcStrobes_t;
endpackage

// File: rtl/dc_datapath.sv
module dc_datapath
  import dc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SET_BITS = 6,
  parameter int OFF_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        memRdata,
  input  logic [OFF_BITS-3:0]      beat,
  input  dcStrobes_t               strobes,
  output logic                     hit,
  output logic                     victimDirty,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-1:0]        respData
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int WAYS  = 4;
  localparam int WORDS = 1 << (OFF_BITS - 2);
  localparam int TAG_W = ADDR_W - OFF_BITS - SET_BITS;

  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [DATA_W-1:0] dataArr  [SETS][WAYS][WORDS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-1:0]   dirtyArr [SETS];
  logic [2:0]        plruArr  [SETS];

  logic [SET_BITS-1:0] idx;
  logic [TAG_W-1:0]    tag;
  logic [OFF_BITS-3:0] wordSel;
  logic [WAYS-1:0]     hitVec;
  logic [1:0]          hitWay;
  logic [1:0]          victimWay;

  assign idx     = addr[OFF_BITS +: SET_BITS];
  assign tag     = addr[ADDR_W-1 -: TAG_W];
  assign wordSel = addr[OFF_BITS-1:2];

  function automatic logic [2:0] plruNext(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n = p;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[idx][w] && (tagArr[idx][w] == tag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = 2'(w);
  end

  always_comb begin
    logic found;
    logic [2:0] p;
    p = plruArr[idx];
    victimWay = p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
    found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !validArr[idx][w]) begin
        victimWay = 2'(w);
        found = 1'b1;
      end
  end

  assign hit         = |hitVec;
  assign victimDirty = validArr[idx][victimWay] && dirtyArr[idx][victimWay];

  always_comb begin
    if (strobes.selVictim)
      memAddr = {tagArr[idx][victimWay], idx, {OFF_BITS{1'b0}}};
    else if (strobes.selWord)
      memAddr = addr;
    else
      memAddr = {tag, idx, {OFF_BITS{1'b0}}};
  end

  assign memWdata = strobes.selVictim ? dataArr[idx][victimWay][beat] : wdata;
  assign respData = strobes.respFromBus ? memRdata : dataArr[idx][hitWay][wordSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        plruArr[s]  <= '0;
      end
    end else begin
      if (strobes.touch) plruArr[idx] <= plruNext(plruArr[idx], hitWay);
      if (strobes.wrHit && strobes.markDirty) dirtyArr[idx][hitWay] <= 1'b1;
      if (strobes.wbDone) dirtyArr[idx][victimWay] <= 1'b0;
      if (strobes.fillDone) begin
        validArr[idx][victimWay] <= 1'b1;
        dirtyArr[idx][victimWay] <= 1'b0;
        plruArr[idx] <= plruNext(plruArr[idx], victimWay);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillDone) tagArr[idx][victimWay] <= tag;
    if (strobes.fillBeat) dataArr[idx][victimWay][beat] <= memRdata;
    if (strobes.wrHit) dataArr[idx][hitWay][wordSel] <= wdata;
  end

  // Tags within a set stay unique, so at most one way can match.
  assert_one_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // A refill never lands on a line still holding unwritten data.
  assert_clean_victim_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillDone |-> !victimDirty);
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int OFF_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                copyBack,
  input  logic                freeze,
  input  logic                hit,
  input  logic                victimDirty,
  input  logic                memAck,
  output logic                respDone,
  output logic                memReq,
  output logic                memWrite,
  output logic                memBurst,
  output logic [OFF_BITS-3:0] beat,
  output dcStrobes_t          strobes
);
  dcState_t state, nextState;
  logic lastBeat;

  assign lastBeat = (beat == '1);

  always_comb begin
    strobes   = '0;
    respDone  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    memBurst  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (hit) begin
          if (!reqWrite) begin
            respDone = 1'b1;
            strobes.touch = 1'b1;
          end else if (copyBack) begin
            respDone = 1'b1;
            strobes.wrHit = 1'b1;
            strobes.markDirty = 1'b1;
            strobes.touch = 1'b1;
          end else begin
            nextState = ST_SINGLE;
          end
        end else if (freeze || (reqWrite && !copyBack)) begin
          nextState = ST_SINGLE;
        end else if (victimDirty) begin
          nextState = ST_WB;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWrite = 1'b1;
        memBurst = 1'b1;
        strobes.selVictim = 1'b1;
        if (memAck && lastBeat) begin
          strobes.wbDone = 1'b1;
          nextState = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        memBurst = 1'b1;
        strobes.fillBeat = memAck;
        if (memAck && lastBeat) begin
          strobes.fillDone = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_SINGLE: begin
        memReq = 1'b1;
        memWrite = reqWrite;
        strobes.selWord = 1'b1;
        strobes.respFromBus = 1'b1;
        if (memAck) begin
          respDone = 1'b1;
          nextState = ST_IDLE;
          if (reqWrite && hit) begin
            strobes.wrHit = 1'b1;
            strobes.touch = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= nextState;
      if (memAck && memBurst) beat <= beat + 1'b1;
    end
  end

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  assert_frozen_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && !hit && freeze) |=> (state == ST_SINGLE));

  assert_wt_waits_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqWrite && !copyBack) |-> !respDone);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !memReq);
endmodule

// File: rtl/lockable_dcache.sv
module lockable_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SET_BITS = 6,
  parameter int OFF_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              copyBack,
  input  logic              freeze,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respDone,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic              memWrite,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  dcStrobes_t          strobes;
  logic                hit;
  logic                victimDirty;
  logic [OFF_BITS-3:0] beat;

  dc_ctrl #(.OFF_BITS(OFF_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .copyBack(copyBack), .freeze(freeze), .hit(hit), .victimDirty(victimDirty),
    .memAck(memAck), .respDone(respDone), .memReq(memReq), .memWrite(memWrite),
    .memBurst(memBurst), .beat(beat), .strobes(strobes)
  );

  dc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS)
  ) dpath (
    .clk(clk), .rstN(rstN), .addr(reqAddr), .wdata(reqWdata), .memRdata(memRdata),
    .beat(beat), .strobes(strobes), .hit(hit), .victimDirty(victimDirty),
    .memAddr(memAddr), .memWdata(memWdata), .respData(respData)
  );
endmodule

// File: tb/lockable_dcache_test.sv
`timescale 1ns/1ps
module lockable_dcache_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic copyBack = 1'b1, freeze = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic respDone, memReq, memWrite, memBurst;
  logic [31:0] respData, memAddr, memWdata;
  logic memAck;
  logic [31:0] memRdata;

  int checks = 0, failures = 0;
  int txnCount = 0;
  logic lastWrite, lastBurst;
  logic [31:0] lastAddr;
  logic [31:0] mem [2048];
  logic [1:0] beatB;

  always #2 clk = ~clk;

  lockable_dcache uut (
    .clk(clk), .rstN(rstN), .copyBack(copyBack), .freeze(freeze),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respDone(respDone), .respData(respData), .memReq(memReq), .memWrite(memWrite),
    .memBurst(memBurst), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] A(input int tg, input int st, input int wd);
    return 32'((tg << 10) | (st << 4) | (wd << 2));
  endfunction

  function automatic logic [31:0] initVal(input logic [31:0] a);
    return 32'hA000_0000 + 32'(a[12:2]);
  endfunction

  // Memory model: one beat acknowledged every second cycle.
  initial begin
    logic [31:0] wa;
    for (int i = 0; i < 2048; i++) mem[i] = 32'hA000_0000 + 32'(i);
    memAck = 1'b0;
    memRdata = '0;
    beatB = '0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        wa = memAddr + 32'(4 * beatB);
        memRdata = mem[wa[12:2]];
        if (memWrite) mem[wa[12:2]] = memWdata;
        if (beatB == 0) begin
          txnCount++;
          lastWrite = memWrite;
          lastBurst = memBurst;
          lastAddr = memAddr;
        end
        beatB = (memBurst && beatB != 2'd3) ? beatB + 2'd1 : 2'd0;
        memAck = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; waits = 0;
    #1;
    while (!respDone) begin
      @(posedge clk); waits++;
      @(negedge clk); #1;
    end
    rd = respData;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic test_reset;
    check(memReq == 1'b0, "R9 memReq", 32'(memReq), 0);
    check(respDone == 1'b0, "R9 respDone", 32'(respDone), 0);
  endtask

  task automatic test_read_miss;
    logic [31:0] rd; int w, t0;
    t0 = txnCount;
    access(0, A(0,2,1), 0, rd, w);
    check(w == 8, "R2 miss latency", 32'(w), 8);
    check(rd == initVal(A(0,2,1)), "R2 miss data", rd, initVal(A(0,2,1)));
    check(txnCount - t0 == 1 && lastBurst && !lastWrite, "R2 one read burst", 32'(txnCount - t0), 1);
    check(lastAddr == A(0,2,0), "R10 burst base", lastAddr, A(0,2,0));
    t0 = txnCount;
    access(0, A(0,2,3), 0, rd, w);
    check(w == 0 && txnCount == t0, "R1 hit latency/no bus", 32'(w), 0);
    check(rd == initVal(A(0,2,3)), "R1 hit data", rd, initVal(A(0,2,3)));
  endtask

  task automatic test_cb_hit;
    logic [31:0] rd; int w, t0;
    t0 = txnCount;
    access(1, A(0,2,1), 32'h1111_0001, rd, w);
    check(w == 0 && txnCount == t0, "R3 store hit no bus", 32'(w), 0);
    access(0, A(0,2,1), 0, rd, w);
    check(rd == 32'h1111_0001, "R3 read back", rd, 32'h1111_0001);
    check(mem[A(0,2,1) >> 2] == initVal(A(0,2,1)), "R3 memory untouched", mem[A(0,2,1) >> 2], initVal(A(0,2,1)));
  endtask

  task automatic test_dirty_evict;
    logic [31:0] rd; int w, t0;
    for (int t = 1; t < 4; t++) access(0, A(t,2,0), 0, rd, w);
    t0 = txnCount;
    access(0, A(4,2,0), 0, rd, w);
    check(w == 16, "R7 writeback then refill latency", 32'(w), 16);
    check(txnCount - t0 == 2 && lastBurst && !lastWrite, "R7 two bursts, refill last", 32'(txnCount - t0), 2);
    check(mem[A(0,2,1) >> 2] == 32'h1111_0001, "R7 dirty word written back", mem[A(0,2,1) >> 2], 32'h1111_0001);
    check(rd == initVal(A(4,2,0)), "R7 refill data", rd, initVal(A(4,2,0)));
  endtask

  task automatic test_write_through;
    logic [31:0] rd; int w, t0;
    copyBack = 1'b0;
    t0 = txnCount;
    access(1, A(4,2,2), 32'h2222_0002, rd, w);
    check(w == 1 && txnCount - t0 == 1 && lastWrite && !lastBurst, "R4 single write", 32'(w), 1);
    check(mem[A(4,2,2) >> 2] == 32'h2222_0002, "R4 memory updated", mem[A(4,2,2) >> 2], 32'h2222_0002);
    check(lastAddr == A(4,2,2), "R10 single word address", lastAddr, A(4,2,2));
    access(0, A(4,2,2), 0, rd, w);
    check(w == 0 && rd == 32'h2222_0002, "R4 cache updated", rd, 32'h2222_0002);
    t0 = txnCount;
    access(1, A(5,3,0), 32'h3333_0003, rd, w);
    check(w == 1 && txnCount - t0 == 1 && !lastBurst, "R5 store miss single write", 32'(w), 1);
    access(0, A(5,3,0), 0, rd, w);
    check(w == 8, "R5 no allocation", 32'(w), 8);
    check(rd == 32'h3333_0003, "R5 data from memory", rd, 32'h3333_0003);
    copyBack = 1'b1;
  endtask

  task automatic test_plru;
    logic [31:0] rd; int w;
    for (int t = 0; t < 4; t++) access(0, A(t,5,0), 0, rd, w);
    access(0, A(0,5,0), 0, rd, w);
    check(w == 0, "R6 way0 hit", 32'(w), 0);
    access(0, A(4,5,0), 0, rd, w);
    check(w == 8, "R6 clean eviction", 32'(w), 8);
    access(0, A(0,5,1), 0, rd, w);
    check(w == 0, "R6 recently used way kept", 32'(w), 0);
    access(0, A(3,5,0), 0, rd, w);
    check(w == 0, "R6 way3 kept", 32'(w), 0);
    access(0, A(2,5,0), 0, rd, w);
    check(w == 8, "R6 way2 was the victim", 32'(w), 8);
  endtask

  task automatic test_freeze;
    logic [31:0] rd; int w, t0;
    access(0, A(0,7,0), 0, rd, w);
    freeze = 1'b1;
    access(0, A(0,7,0), 0, rd, w);
    check(w == 0, "R8 frozen hit", 32'(w), 0);
    t0 = txnCount;
    access(0, A(1,7,1), 0, rd, w);
    check(w == 1 && !lastBurst && txnCount - t0 == 1, "R8 uncached read", 32'(w), 1);
    check(rd == initVal(A(1,7,1)), "R8 uncached data", rd, initVal(A(1,7,1)));
    access(0, A(1,7,1), 0, rd, w);
    check(w == 1, "R8 still not allocated", 32'(w), 1);
    access(1, A(2,7,0), 32'h4444_0004, rd, w);
    check(w == 1 && lastWrite && !lastBurst, "R8 frozen store miss", 32'(w), 1);
    check(mem[A(2,7,0) >> 2] == 32'h4444_0004, "R8 store reached memory", mem[A(2,7,0) >> 2], 32'h4444_0004);
    freeze = 1'b0;
    access(0, A(0,7,0), 0, rd, w);
    check(w == 0, "R8 line survived freeze", 32'(w), 0);
    access(0, A(1,7,1), 0, rd, w);
    check(w == 8, "R8 allocation resumes", 32'(w), 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_read_miss();
    test_cb_hit();
    test_dirty_evict();
    test_write_through();
    test_plru();
    test_freeze();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule